// File: doc/BRIEF.md
# Priority-Threshold Interrupt Controller

This block gathers level-sensitive interrupt flags from a set of source slots and offers the processor one interrupt line. Each slot has a programmable priority. It also has one enable bit for each of its flags and a single mask bit. All flags of a slot are ORed together, so they share one vector. A slot competes only when its priority is strictly above the current-priority register, and the interrupt line is registered.

When the processor acknowledges, the block picks the winner from the state present in that cycle. It reports the slot's vector number and a byte offset of sixteen times that number, and it raises the current priority to the winner's priority. The old current priority is saved on a small LIFO. An end-of-interrupt strobe pops the LIFO back into the current-priority register.

Slots listed in a reserved-slot parameter never raise a request. Register writes use a simple strobe, kind, index and data port: kind 0 writes a priority, kind 1 writes the enable bits and kind 2 writes the mask bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A slot is eligible only when its priority is strictly greater than the current priority; an equal priority does not qualify, and priority 0 never qualifies.
- R2: One cycle after an acknowledge with an eligible slot, ackDone and ackHit are 1, ackVec equals VEC_BASE plus the slot index, ackOfs equals ackVec times 16, and the current priority equals the winner's priority.
- R3: The winner is chosen from flags, enables, masks and priorities as they stand in the acknowledge cycle, so a request that dropped earlier or a priority rewritten just before is honoured as it is then.
- R4: Clearing a slot's enable bits (kind 1) or setting its mask (kind 2, data bit 0 = 1) removes its request exactly as clearing the flag would.
- R5: Setting an enable bit or clearing the mask while the flag is held raises the request exactly as a new flag event would.
- R6: Flag bit f of slot i is srcFlag[i*FLAGS_PER_SRC+f]; any enabled flag of a slot gives that slot's single vector.
- R7: Slots whose bit is set in RSVD_SLOTS (slot 6 by default) never request, even when flagged, enabled and given a priority.
- R8: Among eligible slots the highest priority wins; on a tie the lowest slot index wins.
- R9: Each successful acknowledge pushes the old current priority onto a LIFO of STACK_DEPTH (8) entries. A push into a full LIFO is dropped, but the current priority still updates. End-of-interrupt pops into the current priority, and a pop of an empty LIFO leaves it unchanged.
- R10: irq is registered and reflects eligibility one cycle after any change to flags, enables, masks, priorities or current priority.
- R11: An acknowledge with no eligible slot gives ackDone 1, ackHit 0, ackVec 0, and leaves the current priority and the LIFO unchanged.
- R12: When acknowledge and end-of-interrupt arrive in the same cycle, the acknowledge takes effect and the end-of-interrupt is dropped.
- R13: After reset irq, ackDone and curPrio are 0, and all priorities, enables and masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcFlag | input | NUM_SRC*FLAGS_PER_SRC | Level flags, FLAGS_PER_SRC per slot |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | 0 priority, 1 enables, 2 mask, 3 ignored |
| wrIdx | input | $clog2(NUM_SRC) | Target slot |
| wrData | input | max(PRIO_W,FLAGS_PER_SRC) | Write data |
| ack | input | 1 | Processor acknowledge |
| eoi | input | 1 | End of interrupt |
| irq | output | 1 | Registered interrupt to processor |
| ackDone | output | 1 | Acknowledge response valid |
| ackHit | output | 1 | A slot was granted |
| ackVec | output | VEC_W | Granted vector number |
| ackOfs | output | VEC_W+4 | Granted vector byte offset |
| curPrio | output | PRIO_W | Current priority register |

## Verification
Acknowledge and end-of-interrupt can land in the same cycle, and both want to rewrite the current priority and the LIFO. The bench raises both strobes together while a nested interrupt is pending. It then checks that the current priority becomes the new winner's priority. Two further end-of-interrupt strobes must then unwind through exactly the previously saved values, which shows that no pop occurred.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    WK_PRIO   = 2'd0,
    WK_ENABLE = 2'd1,
    WK_MASK   = 2'd2
  } wrKind_e;

  typedef struct packed {
    logic setPrio;
    logic setEnable;
    logic setMask;
    logic take;
    logic retire;
  } strobe_t;
endpackage

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrKind,
  input  logic       ack,
  input  logic       eoi,
  output strobe_t    stb
);
  wrKind_e kind;
  assign kind = wrKind_e'(wrKind);

  always_comb begin
    stb.setPrio   = wrEn && (kind == WK_PRIO);
    stb.setEnable = wrEn && (kind == WK_ENABLE);
    stb.setMask   = wrEn && (kind == WK_MASK);
    stb.take      = ack;
    // acknowledge wins over a coincident end-of-interrupt (R12)
    stb.retire    = eoi && !ack;
  end
endmodule

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC       = 8,
  parameter int FLAGS_PER_SRC = 2,
  parameter int PRIO_W        = 4,
  parameter int STACK_DEPTH   = 8,
  parameter int VEC_BASE      = 470,
  parameter logic [NUM_SRC-1:0] RSVD_SLOTS = 8'b0100_0000,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int DATA_W = (PRIO_W > FLAGS_PER_SRC) ? PRIO_W : FLAGS_PER_SRC,
  localparam int VEC_W  = $clog2(VEC_BASE + NUM_SRC),
  localparam int PTR_W  = $clog2(STACK_DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SRC*FLAGS_PER_SRC-1:0] srcFlag,
  input  strobe_t                          stb,
  input  logic [IDX_W-1:0]                 wrIdx,
  input  logic [DATA_W-1:0]                wrData,
  output logic                             irq,
  output logic                             ackDone,
  output logic                             ackHit,
  output logic [VEC_W-1:0]                 ackVec,
  output logic [PRIO_W-1:0]                curPrio,
  output logic                             anyElig,
  output logic [PRIO_W-1:0]                bestPrio
);
  logic [PRIO_W-1:0]        prioQ [NUM_SRC];
  logic [FLAGS_PER_SRC-1:0] enQ   [NUM_SRC];
  logic [NUM_SRC-1:0]       maskQ;
  logic [NUM_SRC-1:0]       req;
  logic [PRIO_W-1:0]        stkQ  [STACK_DEPTH];
  logic [CNT_W-1:0]         cntQ;
  logic [CNT_W-1:0]         popIdx;
  logic [PRIO_W-1:0]        curQ;
  logic [IDX_W-1:0]         bestIdx;
  logic                     irqQ, ackDoneQ, ackHitQ;
  logic [VEC_W-1:0]         ackVecQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_req
    if (RSVD_SLOTS[i]) begin : g_rsvd
      assign req[i] = 1'b0;
    end else begin : g_live
      assign req[i] = (|(srcFlag[i*FLAGS_PER_SRC +: FLAGS_PER_SRC] & enQ[i])) && !maskQ[i];
    end
  end

  // linear scan, ascending index, strict compare keeps lowest index on ties
  always_comb begin
    anyElig  = 1'b0;
    bestPrio = '0;
    bestIdx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (prioQ[i] > curQ) && (!anyElig || prioQ[i] > bestPrio)) begin
        anyElig  = 1'b1;
        bestPrio = prioQ[i];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  assign popIdx = cntQ - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        prioQ[i] <= '0;
        enQ[i]   <= '0;
      end
      for (int j = 0; j < STACK_DEPTH; j++) stkQ[j] <= '0;
      maskQ    <= '0;
      cntQ     <= '0;
      curQ     <= '0;
      irqQ     <= 1'b0;
      ackDoneQ <= 1'b0;
      ackHitQ  <= 1'b0;
      ackVecQ  <= '0;
    end else begin
      if (stb.setPrio)   prioQ[wrIdx] <= wrData[PRIO_W-1:0];
      if (stb.setEnable) enQ[wrIdx]   <= wrData[FLAGS_PER_SRC-1:0];
      if (stb.setMask)   maskQ[wrIdx] <= wrData[0];
      irqQ     <= anyElig;
      ackDoneQ <= stb.take;
      if (stb.take) begin
        ackHitQ <= anyElig;
        ackVecQ <= anyElig ? (VEC_W'(VEC_BASE) + VEC_W'(bestIdx)) : '0;
        if (anyElig) begin
          curQ <= bestPrio;
          if (cntQ < CNT_W'(STACK_DEPTH)) begin
            stkQ[cntQ[PTR_W-1:0]] <= curQ;
            cntQ <= cntQ + 1'b1;
          end
        end
      end else if (stb.retire && cntQ != '0) begin
        curQ <= stkQ[popIdx[PTR_W-1:0]];
        cntQ <= popIdx;
      end
    end
  end

  assign irq     = irqQ;
  assign ackDone = ackDoneQ;
  assign ackHit  = ackHitQ;
  assign ackVec  = ackVecQ;
  assign curPrio = curQ;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC       = 8,
  parameter int FLAGS_PER_SRC = 2,
  parameter int PRIO_W        = 4,
  parameter int STACK_DEPTH   = 8,
  parameter int VEC_BASE      = 470,
  parameter logic [NUM_SRC-1:0] RSVD_SLOTS = 8'b0100_0000,
  localparam int IDX_W     = $clog2(NUM_SRC),
  localparam int DATA_W    = (PRIO_W > FLAGS_PER_SRC) ? PRIO_W : FLAGS_PER_SRC,
  localparam int VEC_W     = $clog2(VEC_BASE + NUM_SRC),
  localparam int OFS_SHIFT = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SRC*FLAGS_PER_SRC-1:0] srcFlag,
  input  logic                             wrEn,
  input  logic [1:0]                       wrKind,
  input  logic [IDX_W-1:0]                 wrIdx,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             ack,
  input  logic                             eoi,
  output logic                             irq,
  output logic                             ackDone,
  output logic                             ackHit,
  output logic [VEC_W-1:0]                 ackVec,
  output logic [VEC_W+OFS_SHIFT-1:0]       ackOfs,
  output logic [PRIO_W-1:0]                curPrio
);
  strobe_t           stb;
  logic              anyElig;
  logic [PRIO_W-1:0] bestPrio;

  prio_irq_ctl u_ctl (
    .wrEn(wrEn), .wrKind(wrKind), .ack(ack), .eoi(eoi), .stb(stb)
  );

  prio_irq_dp #(
    .NUM_SRC(NUM_SRC), .FLAGS_PER_SRC(FLAGS_PER_SRC), .PRIO_W(PRIO_W),
    .STACK_DEPTH(STACK_DEPTH), .VEC_BASE(VEC_BASE), .RSVD_SLOTS(RSVD_SLOTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .stb(stb), .wrIdx(wrIdx),
    .wrData(wrData), .irq(irq), .ackDone(ackDone), .ackHit(ackHit),
    .ackVec(ackVec), .curPrio(curPrio), .anyElig(anyElig), .bestPrio(bestPrio)
  );

  assign ackOfs = {ackVec, {OFS_SHIFT{1'b0}}};
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ack,
  input logic              eoi,
  input logic              irq,
  input logic              ackDone,
  input logic              ackHit,
  input logic [PRIO_W-1:0] curPrio,
  input logic              anyElig,
  input logic [PRIO_W-1:0] bestPrio
);
  a_r2_ack_answers: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> ackDone);

  a_r2_cur_loads_winner: assert property (@(posedge clk) disable iff (!rstN)
    (ack && anyElig) |=> (curPrio == $past(bestPrio)) && ackHit);

  a_r1_cur_rises: assert property (@(posedge clk) disable iff (!rstN)
    (ack && anyElig) |=> curPrio > $past(curPrio));

  a_r11_empty_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !anyElig) |=> $stable(curPrio) && !ackHit);

  a_r9_pop_never_raises: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && !ack) |=> curPrio <= $past(curPrio));

  a_r10_irq_registered: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(anyElig));

  a_r12_ack_over_eoi: assert property (@(posedge clk) disable iff (!rstN)
    (ack && eoi && anyElig) |=> curPrio == $past(bestPrio));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .eoi(eoi), .irq(irq),
  .ackDone(ackDone), .ackHit(ackHit), .curPrio(curPrio),
  .anyElig(anyElig), .bestPrio(bestPrio)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int BASE = 470;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcFlag = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrKind = '0;
  logic [2:0]  wrIdx = '0;
  logic [3:0]  wrData = '0;
  logic        ack = 1'b0, eoi = 1'b0;
  logic        irq, ackDone, ackHit;
  logic [8:0]  ackVec;
  logic [12:0] ackOfs;
  logic [3:0]  curPrio;

  int checkCnt = 0, failCnt = 0;
  bit finished = 0;

  typedef struct { bit hit; int vec; int cur; string tag; } exp_t;
  exp_t sbQ[$];

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .wrEn(wrEn), .wrKind(wrKind),
    .wrIdx(wrIdx), .wrData(wrData), .ack(ack), .eoi(eoi), .irq(irq),
    .ackDone(ackDone), .ackHit(ackHit), .ackVec(ackVec), .ackOfs(ackOfs),
    .curPrio(curPrio)
  );

  task automatic chk(int act, int exp, string tag);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  // monitor: pops expected acknowledge results as the design produces them
  always @(negedge clk) begin
    if (rstN && ackDone) begin
      if (sbQ.size() == 0) chk(1, 0, "R2 unexpected ackDone");
      else begin
        exp_t e;
        e = sbQ.pop_front();
        chk(int'(ackHit), int'(e.hit), {e.tag, " hit"});
        chk(int'(ackVec), e.vec, {e.tag, " vec"});
        chk(int'(ackOfs), e.vec * 16, {e.tag, " ofs"});
        chk(int'(curPrio), e.cur, {e.tag, " cur"});
      end
    end
  end

  task automatic wr(int kind, int idx, int data);
    @(negedge clk);
    wrEn = 1'b1; wrKind = 2'(kind); wrIdx = 3'(idx); wrData = 4'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic doAck(bit hit, int slot, int cur, string tag, bit withEoi = 0);
    exp_t e;
    e.hit = hit; e.vec = hit ? BASE + slot : 0; e.cur = cur; e.tag = tag;
    @(negedge clk);
    sbQ.push_back(e);
    ack = 1'b1; eoi = withEoi;
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic doEoi(int expCur, string tag);
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    chk(int'(curPrio), expCur, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(irq), 0, "R13 irq after reset");
    chk(int'(curPrio), 0, "R13 cur after reset");
    chk(int'(ackDone), 0, "R13 ackDone after reset");
    rstN = 1'b1;

    // R1: priority 0 never qualifies
    srcFlag[4] = 1'b1;
    wr(1, 2, 1);
    settle();
    chk(int'(irq), 0, "R1 priority zero");

    // R5 / R10: enable while flag held, irq one cycle later
    srcFlag[2] = 1'b1;
    wr(0, 1, 5);
    settle();
    chk(int'(irq), 0, "R13 enable reset value");
    wr(1, 1, 1);
    chk(int'(irq), 0, "R10 irq not yet updated");
    @(negedge clk);
    chk(int'(irq), 1, "R10 irq one cycle later");

    // R4 / R5: mask and enable act like flag events
    wr(2, 1, 1); settle();
    chk(int'(irq), 0, "R4 mask removes request");
    wr(2, 1, 0); settle();
    chk(int'(irq), 1, "R5 unmask raises request");
    wr(1, 1, 0); settle();
    chk(int'(irq), 0, "R4 disable removes request");
    for (int i = 0; i < 8; i++) wr(1, i, 3);
    settle();
    chk(int'(irq), 1, "R5 re-enable raises request");

    // R2: acknowledge slot 1, then equal priority is not eligible
    doAck(1, 1, 5, "R2 ack slot1");
    settle();
    chk(int'(irq), 0, "R1 equal priority blocked");

    // R6: second flag of slot 3, vector 473 -> 0x1D90
    srcFlag[7] = 1'b1;
    wr(0, 3, 5); settle();
    chk(int'(irq), 0, "R1 equal priority slot3");
    wr(0, 3, 6); settle();
    chk(int'(irq), 1, "R1 higher priority presented");
    doAck(1, 3, 6, "R6 ack slot3 offset 0x1D90");

    // R9: unwind and empty pop
    doEoi(5, "R9 pop to 5");
    doEoi(0, "R9 pop to 0");
    doEoi(0, "R9 empty pop unchanged");
    srcFlag = '0;

    // R8: tie and priority order
    wr(0, 4, 7); wr(0, 5, 7);
    srcFlag[8] = 1'b1; srcFlag[10] = 1'b1;
    doAck(1, 4, 7, "R8 tie lowest slot");
    doEoi(0, "R9 pop after tie");
    wr(0, 5, 9);
    doAck(1, 5, 9, "R8 higher priority wins");
    doEoi(0, "R9 pop after R8");
    srcFlag = '0;

    // R7 / R11: reserved slot never requests
    wr(0, 6, 10);
    srcFlag[12] = 1'b1;
    settle();
    chk(int'(irq), 0, "R7 reserved slot silent");
    doAck(0, 0, 0, "R11 empty ack");
    srcFlag = '0;

    // R3: state at acknowledge time decides
    wr(0, 2, 12); wr(0, 7, 3);
    srcFlag[4] = 1'b1; srcFlag[14] = 1'b1;
    settle();
    chk(int'(irq), 1, "R3 pending");
    srcFlag[4] = 1'b0;
    doAck(1, 7, 3, "R3 dropped source not used");
    srcFlag[4] = 1'b1;
    wr(0, 2, 13);
    doAck(1, 2, 13, "R3 returned source fresh priority");
    doEoi(3, "R9 pop to 3");
    doEoi(0, "R9 pop to 0 again");
    srcFlag = '0;

    // R12: acknowledge and end-of-interrupt together
    wr(0, 1, 4);
    srcFlag[2] = 1'b1;
    doAck(1, 1, 4, "R2 ack slot1 prio4");
    wr(0, 4, 8);
    srcFlag[8] = 1'b1;
    doAck(1, 4, 8, "R12 ack wins over eoi", 1'b1);
    doEoi(4, "R12 eoi dropped, saved 4");
    doEoi(0, "R12 saved 0");
    doEoi(0, "R12 stack empty");
    srcFlag = '0;

    // R9: nest nine deep into an eight-entry LIFO
    srcFlag[0] = 1'b1;
    for (int p = 1; p <= 9; p++) begin
      wr(0, 0, p);
      doAck(1, 0, p, "R9 nested ack");
    end
    for (int k = 7; k >= 0; k--) doEoi(k, "R9 full LIFO unwind");
    doEoi(0, "R9 overflow push dropped");
    srcFlag = '0;

    settle();
    chk(sbQ.size(), 0, "R2 all acks answered");
    finished = 1;
    summary();
  end
endmodule